// File: doc/BRIEF.md
# Security-Aware Interrupt Priority and Mask Register File

This block holds the 8-bit priority of every interrupt in an interrupt controller and the 8-bit running-priority mask of every CPU interface. It is reached over a simple register bus. Each request carries a region select, a 12-bit offset, a write strobe, 32-bit write data, the requesting CPU index and a secure attribute. The response comes back one cycle after the request. It carries read data and an error flag.

When the `SEC_EN` parameter is set, a non-secure request gets a restricted view. Non-secure priority writes are folded into the upper half of the range (values 0x80 to 0xFF). Priorities of group 0 interrupts are hidden from non-secure software. A non-secure request can change the mask only while the mask already lies in the upper half. Secure requests, and every request when `SEC_EN` is clear, see the stored bytes unchanged. The group of each interrupt comes in as a plain input vector (1 = group 1). Interrupts 0 to 31 have a private priority byte per CPU. Higher interrupts share one byte.

Top module: `irq_prio_regs`

## Requirements
- R1: After reset every priority byte and every CPU mask reads as zero.
- R2: A secure request, or any request when SEC_EN is 0, writes the low data byte unchanged and reads the stored byte unchanged in rdata[7:0].
- R3: With SEC_EN set, a non-secure priority write to an interrupt whose irq_group bit is 0 leaves the stored priority unchanged.
- R4: With SEC_EN set, a non-secure priority write to a group 1 interrupt stores 0x80 | (wdata[7:0] >> 1).
- R5: With SEC_EN set, a non-secure priority read of a group 0 interrupt returns 0.
- R6: With SEC_EN set, a non-secure priority read of a group 1 interrupt returns (stored << 1) & 0xFF.
- R7: With SEC_EN set, a non-secure mask write stores 0x80 | (wdata[7:0] >> 1) when bit 7 of the current mask is 1, and is dropped when that bit is 0.
- R8: With SEC_EN set, a non-secure mask read returns (mask << 1) & 0xFF when mask bit 7 is 1, and 0 otherwise.
- R9: Priorities of interrupts 0 to 31 are kept separately per CPU (selected by cpu_idx). Interrupts 32 and up have a single copy shared by all CPUs.
- R10: An error response (resp_err = 1, rdata = 0, no state change) is given for: a region-0 offset outside 0x400 to 0x400+NUM_IRQ-1; a region-1 offset other than 0x004; or cpu_idx >= NUM_CPU.
- R11: resp_valid is 1 exactly in the cycle after a cycle with req_valid = 1. Only wdata[7:0] is used for writes. rdata[31:8] is always 0, and rdata is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_region | input | 1 | 0 = distributor priority space, 1 = CPU interface space |
| req_addr | input | 12 | Byte offset within the region |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data; only bits 7:0 are used |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_secure | input | 1 | 1 = secure request |
| irq_group | input | NUM_IRQ | Group of each interrupt, 1 = group 1 |
| resp_valid | output | 1 | Response present (one cycle after the request) |
| resp_err | output | 1 | Error response |
| resp_rdata | output | 32 | Read data |

## Verification
The assertions take for granted that req_secure and irq_group are stable for the whole request cycle. They also take for granted that reset is asserted before the first request, so every response pairs with a request seen after reset. The stimulus changes inputs only on the falling edge and issues at most one request per cycle. It changes irq_group only between requests, never while a response is pending. An instance with SEC_EN set and one with SEC_EN clear receive the same traffic, so both views are checked against a single model driven by the same requests.

// File: rtl/irq_prio_regs_pkg.sv
package irq_prio_regs_pkg;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned BANKED_IRQS = 32;
  localparam logic [ADDR_W-1:0] PRIO_BASE = 12'h400;
  localparam logic [ADDR_W-1:0] MASK_OFS  = 12'h004;

  typedef enum logic {
    RGN_DIST  = 1'b0,
    RGN_CPUIF = 1'b1
  } region_e;

  // restricted view: value folded into the upper half on the way in
  function automatic logic [PRIO_W-1:0] fold_in(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

  // restricted view: stored value unfolded on the way out
  function automatic logic [PRIO_W-1:0] fold_out(input logic [PRIO_W-1:0] v);
    return {v[PRIO_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
  import irq_prio_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned IRQ_W  = $clog2(NUM_IRQ),
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              req_valid,
  input  logic              req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic              prio_hit,
  output logic              mask_hit,
  output logic              addr_err,
  output logic [IRQ_W-1:0]  irq_idx
);
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(int'(PRIO_BASE) + NUM_IRQ);

  logic              cpu_ok;
  logic [ADDR_W-1:0] ofs;

  assign cpu_ok  = (int'(req_cpu) < NUM_CPU);
  assign ofs     = req_addr - PRIO_BASE;
  assign irq_idx = ofs[IRQ_W-1:0];

  always_comb begin
    prio_hit = req_valid && cpu_ok && (region_e'(req_region) == RGN_DIST) &&
               (req_addr >= PRIO_BASE) && (req_addr < PRIO_END);
    mask_hit = req_valid && cpu_ok && (region_e'(req_region) == RGN_CPUIF) &&
               (req_addr == MASK_OFS);
    addr_err = req_valid && !prio_hit && !mask_hit;
  end
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
  import irq_prio_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned IRQ_W  = $clog2(NUM_IRQ),
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned SHARED = NUM_IRQ - BANKED_IRQS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_W-1:0]  cpu,
  input  logic [IRQ_W-1:0]  irq,
  input  logic [PRIO_W-1:0] wval,
  output logic [PRIO_W-1:0] rd_val
);
  logic              is_banked;
  logic [4:0]        bank_idx;
  logic [PRIO_W-1:0] bank_q [NUM_CPU][BANKED_IRQS];
  logic [PRIO_W-1:0] bank_rd;
  logic [PRIO_W-1:0] shared_rd;

  assign bank_idx = irq[4:0];
  assign bank_rd  = bank_q[cpu][bank_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int i = 0; i < BANKED_IRQS; i++)
          bank_q[c][i] <= '0;
    end else if (wr_en && is_banked) begin
      bank_q[cpu][bank_idx] <= wval;
    end
  end

  generate
    if (SHARED > 0) begin : g_shared
      logic [PRIO_W-1:0] shared_q [SHARED];
      logic [IRQ_W-1:0]  sh_idx;

      assign is_banked = ~|irq[IRQ_W-1:5];
      assign sh_idx    = irq - IRQ_W'(BANKED_IRQS);
      assign shared_rd = shared_q[sh_idx];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SHARED; i++) shared_q[i] <= '0;
        end else if (wr_en && !is_banked) begin
          shared_q[sh_idx] <= wval;
        end
      end
    end else begin : g_no_shared
      assign is_banked = 1'b1;
      assign shared_rd = '0;
    end
  endgenerate

  assign rd_val = is_banked ? bank_rd : shared_rd;
endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store
  import irq_prio_regs_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_W-1:0]  cpu,
  input  logic [PRIO_W-1:0] wval,
  output logic [PRIO_W-1:0] rd_val
);
  logic [PRIO_W-1:0] mask_q [NUM_CPU];

  assign rd_val = mask_q[cpu];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) mask_q[c] <= '0;
    end else if (wr_en) begin
      mask_q[cpu] <= wval;
    end
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter bit          SEC_EN  = 1'b1,
  localparam int unsigned IRQ_W  = $clog2(NUM_IRQ),
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic              req_secure,
  input  logic [NUM_IRQ-1:0] irq_group,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata
);
  // named internal events (observed by the bound checker)
  logic              prio_hit, mask_hit, addr_err;
  logic [IRQ_W-1:0]  irq_idx;
  logic              ns_view;
  logic              grp_sel;
  logic              prio_ns_block, mask_ns_block;
  logic              prio_wr_en, mask_wr_en;
  logic [PRIO_W-1:0] prio_wr_val, mask_wr_val;
  logic [PRIO_W-1:0] prio_cur, cur_mask;
  logic [PRIO_W-1:0] rd_byte;
  logic [PRIO_W-1:0] wbyte;
  logic              unused_wdata_hi;

  assign wbyte           = req_wdata[PRIO_W-1:0];
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:PRIO_W];

  irq_prio_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_dec (
    .req_valid (req_valid),
    .req_region(req_region),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .prio_hit  (prio_hit),
    .mask_hit  (mask_hit),
    .addr_err  (addr_err),
    .irq_idx   (irq_idx)
  );

  assign ns_view = SEC_EN && !req_secure;
  assign grp_sel = prio_hit ? irq_group[irq_idx] : 1'b0;

  assign prio_ns_block = ns_view && !grp_sel;
  assign mask_ns_block = ns_view && !cur_mask[PRIO_W-1];

  assign prio_wr_en  = prio_hit && req_we && !prio_ns_block;
  assign mask_wr_en  = mask_hit && req_we && !mask_ns_block;
  assign prio_wr_val = ns_view ? fold_in(wbyte) : wbyte;
  assign mask_wr_val = ns_view ? fold_in(wbyte) : wbyte;

  irq_prio_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (prio_wr_en),
    .cpu   (req_cpu),
    .irq   (irq_idx),
    .wval  (prio_wr_val),
    .rd_val(prio_cur)
  );

  irq_mask_store #(.NUM_CPU(NUM_CPU)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (mask_wr_en),
    .cpu   (req_cpu),
    .wval  (mask_wr_val),
    .rd_val(cur_mask)
  );

  always_comb begin
    rd_byte = '0;
    if (prio_hit) begin
      if (prio_ns_block)  rd_byte = '0;
      else if (ns_view)   rd_byte = fold_out(prio_cur);
      else                rd_byte = prio_cur;
    end else if (mask_hit) begin
      if (mask_ns_block)  rd_byte = '0;
      else if (ns_view)   rd_byte = fold_out(cur_mask);
      else                rd_byte = cur_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= addr_err;
      resp_rdata <= (req_valid && !req_we && !addr_err) ?
                    {{(DATA_W-PRIO_W){1'b0}}, rd_byte} : '0;
    end
  end
endmodule

// File: rtl/irq_prio_regs_chk.sv
module irq_prio_regs_chk
  import irq_prio_regs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [DATA_W-1:0] req_wdata,
  input logic              resp_valid,
  input logic              resp_err,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              prio_hit,
  input logic              mask_hit,
  input logic              addr_err,
  input logic              ns_view,
  input logic              grp_sel,
  input logic [PRIO_W-1:0] cur_mask,
  input logic              prio_wr_en,
  input logic              mask_wr_en,
  input logic [PRIO_W-1:0] prio_wr_val,
  input logic [PRIO_W-1:0] mask_wr_val
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R11
  AST_NO_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R11
  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rdata[DATA_W-1:PRIO_W] == '0); // R11
  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!prio_wr_en && !mask_wr_en)); // R10
  AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_rdata == '0)); // R10
  AST_NS_G0_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_hit && ns_view && !grp_sel) |-> !prio_wr_en); // R3
  AST_NS_PRIO_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_wr_en && ns_view) |-> prio_wr_val[PRIO_W-1]); // R4
  AST_NS_MASK_LOW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hit && ns_view && !cur_mask[PRIO_W-1]) |-> !mask_wr_en); // R7
  AST_NS_MASK_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && ns_view) |-> mask_wr_val[PRIO_W-1]); // R7
  AST_SEC_MASK_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && !ns_view) |-> (mask_wr_val == req_wdata[PRIO_W-1:0])); // R2
  AST_NS_READ_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_valid && !req_we && ns_view)) |-> !resp_rdata[0]); // R8
endmodule

bind irq_prio_regs irq_prio_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_wdata  (req_wdata),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .resp_rdata (resp_rdata),
  .prio_hit   (prio_hit),
  .mask_hit   (mask_hit),
  .addr_err   (addr_err),
  .ns_view    (ns_view),
  .grp_sel    (grp_sel),
  .cur_mask   (cur_mask),
  .prio_wr_en (prio_wr_en),
  .mask_wr_en (mask_wr_en),
  .prio_wr_val(prio_wr_val),
  .mask_wr_val(mask_wr_val)
);

// File: tb/tb_irq_prio_regs.sv
module tb_irq_prio_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 64;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_region = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [0:0]  req_cpu = '0;
  logic        req_secure = 1'b1;
  logic [NIRQ-1:0] grp = '0;

  logic        rv [2];
  logic        re [2];
  logic [31:0] rd [2];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // model: index 0 = restricted-view instance, 1 = unrestricted instance
  logic [7:0] m_bank [2][NCPU][32];
  logic [7:0] m_shared [2][NIRQ-32];
  logic [7:0] m_mask [2][NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .SEC_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .req_secure(req_secure), .irq_group(grp),
    .resp_valid(rv[0]), .resp_err(re[0]), .resp_rdata(rd[0]));

  irq_prio_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .SEC_EN(1'b0)) dut_open (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .req_secure(req_secure), .irq_group(grp),
    .resp_valid(rv[1]), .resp_err(re[1]), .resp_rdata(rd[1]));

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual valid/err/data=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_err(input bit rg, input int addr, input int cpu);
    if (cpu >= NCPU) return 1;
    if (!rg) return !(addr >= 'h400 && addr < 'h400 + NIRQ);
    return addr != 'h004;
  endfunction

  function automatic int stored_prio(input int d, input int irq, input int cpu);
    if (irq < 32) return int'(m_bank[d][cpu][irq]);
    return int'(m_shared[d][irq-32]);
  endfunction

  // expected read byte, computed arithmetically
  function automatic int exp_read(input int d, input bit rg, input int addr, input int cpu, input bit sec);
    bit ns = (d == 0) && !sec;
    int v;
    if (!rg) begin
      v = stored_prio(d, addr - 'h400, cpu);
      if (!ns) return v;
      return grp[addr - 'h400] ? (v * 2) % 256 : 0;
    end
    v = int'(m_mask[d][cpu]);
    if (!ns) return v;
    return (v >= 128) ? (v * 2) % 256 : 0;
  endfunction

  task automatic mdl_write(input int d, input bit rg, input int addr, input int w, input int cpu, input bit sec);
    bit ns = (d == 0) && !sec;
    int irq;
    int nv = ns ? 128 + w / 2 : w;
    if (!rg) begin
      irq = addr - 'h400;
      if (ns && !grp[irq]) return;
      if (irq < 32) m_bank[d][cpu][irq] = 8'(nv);
      else m_shared[d][irq-32] = 8'(nv);
    end else begin
      if (ns && m_mask[d][cpu] < 128) return;
      m_mask[d][cpu] = 8'(nv);
    end
  endtask

  task automatic acc(input string req, input bit rg, input int addr, input bit wr,
                     input logic [31:0] wd, input int cpu, input bit sec);
    logic [33:0] exp [2];
    bit e;
    @(negedge clk);
    req_valid = 1; req_region = rg; req_addr = 12'(addr); req_we = wr;
    req_wdata = wd; req_cpu = 1'(cpu); req_secure = sec;
    e = is_err(rg, addr, cpu);
    for (int d = 0; d < 2; d++) begin
      if (e) exp[d] = {2'b11, 32'h0};
      else if (wr) exp[d] = {2'b10, 32'h0};
      else exp[d] = {2'b10, 24'h0, 8'(exp_read(d, rg, addr, cpu, sec))};
      if (!e && wr) mdl_write(d, rg, addr, int'(wd[7:0]), cpu, sec);
    end
    @(negedge clk);
    req_valid = 0;
    chk({req, " view=restricted"}, {rv[0], re[0], rd[0]}, exp[0]);
    chk({req, " view=open"}, {rv[1], re[1], rd[1]}, exp[1]);
  endtask

  task automatic idle_check;
    @(negedge clk);
    chk("R11 no response when idle", {rv[0], re[0], rd[0]}, 34'h0);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < NCPU; c++) begin
        m_mask[d][c] = 0;
        for (int i = 0; i < 32; i++) m_bank[d][c][i] = 0;
      end
      for (int i = 0; i < NIRQ-32; i++) m_shared[d][i] = 0;
    end
    for (int i = 0; i < NIRQ; i++) grp[i] = 1'(i ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state of all bytes and masks
    for (int c = 0; c < NCPU; c++) begin
      for (int i = 0; i < NIRQ; i++) acc("R1 prio reset", 0, 'h400 + i, 0, 0, c, 1);
      acc("R1 mask reset", 1, 'h004, 0, 0, c, 1);
    end
    idle_check();

    // R2/R9: secure writes of distinct values per CPU, then secure reads
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NIRQ; i++)
        acc("R2 R9 secure prio write", 0, 'h400 + i, 1, 32'((i * 7 + c * 3 + 1) % 256), c, 1);
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NIRQ; i++)
        acc("R2 R9 secure prio read", 0, 'h400 + i, 0, 0, c, 1);

    // R5/R6: non-secure reads of both groups
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NIRQ; i++)
        acc("R5 R6 non-secure prio read", 0, 'h400 + i, 0, 0, c, 0);

    // R3/R4: non-secure writes, observed through secure reads
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NIRQ; i++)
        acc("R3 R4 non-secure prio write", 0, 'h400 + i, 1, 32'((i * 29 + c * 101 + 5) % 256), c, 0);
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NIRQ; i++)
        acc("R3 R4 R9 readback after non-secure write", 0, 'h400 + i, 0, 0, c, 1);

    // group change, then restricted reads again
    @(negedge clk);
    grp = ~grp;
    for (int i = 0; i < NIRQ; i++) acc("R5 R6 after group flip", 0, 'h400 + i, 0, 0, 0, 0);

    // R7/R8: exhaustive sweep of starting mask value
    for (int c = 0; c < NCPU; c++)
      for (int v = 0; v < 256; v++) begin
        acc("R2 secure mask write", 1, 'h004, 1, 32'(v), c, 1);
        acc("R8 non-secure mask read", 1, 'h004, 0, 0, c, 0);
        acc("R7 non-secure mask write", 1, 'h004, 1, 32'((v * 37 + 11) % 256), c, 0);
        acc("R7 mask readback", 1, 'h004, 0, 0, c, 1);
        acc("R8 non-secure mask read after write", 1, 'h004, 0, 0, c, 0);
      end

    // R11: upper write bits ignored
    acc("R11 mask write high junk", 1, 'h004, 1, 32'hDEAD_BE5A, 0, 1);
    acc("R11 mask readback", 1, 'h004, 0, 0, 0, 1);
    acc("R11 prio write high junk", 0, 'h400 + 40, 1, 32'hFFFF_FF13, 1, 1);
    acc("R11 prio readback", 0, 'h400 + 40, 0, 0, 0, 1);
    idle_check();

    // R10: error responses without state change
    for (int k = 0; k < 8; k++) begin
      acc("R10 prio out of range write", 0, 'h400 + NIRQ + k * 9, 1, 32'h77, 0, 1);
      acc("R10 prio out of range read", 0, 'h400 + NIRQ + k * 9, 0, 0, 1, 0);
    end
    acc("R10 dist offset below base", 0, 'h3FF, 1, 32'h55, 0, 1);
    acc("R10 cpuif wrong offset", 1, 'h008, 1, 32'h55, 0, 1);
    acc("R10 cpuif offset zero", 1, 'h000, 0, 0, 1, 1);
    for (int c = 0; c < NCPU; c++) begin
      acc("R10 mask unchanged", 1, 'h004, 0, 0, c, 1);
      for (int i = 0; i < NIRQ; i++) acc("R10 prio unchanged", 0, 'h400 + i, 0, 0, c, 1);
    end
    idle_check();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule